// File: doc/BRIEF.md
# Chip-Rate Sample Pair Averager

This stage sits in front of the correlator of a despreading receiver. The I and Q baseband streams arrive at two samples per chip. For each accepted input, every channel adds the new sample to the sample accepted just before it, which gives the response 1 + z^-1. It then turns the sum into a 3-bit offset code. The code has no zero level. Code k stands for the value k - 3.5, so the eight levels are the odd half-units from -3.5 to +3.5.

An integer sum always lies exactly halfway between two levels. The rounding therefore alternates direction so that it adds no DC bias. Each channel keeps a one-bit tie direction. A non-saturated sum rounds up when the direction is clear and down when it is set. The direction flips after every such rounding. Sums outside the level range go to the end codes and leave the direction unchanged.

A bypass pin turns the summing off. In bypass, the current sample alone goes through the same mapping, so the correlator always sees the same format.

Both edges of the stage are valid/ready streams. A sample transfers on a cycle with in_valid and in_ready both high. Its codes are presented, registered, from the next cycle. The output holds still until out_ready accepts it. in_ready is high whenever the output register is empty or is being drained in the same cycle, so a full stream runs at one sample per clock. The bypass pin is sampled in the cycle a sample transfers.

Top module: `chip_pair_avg`

## Requirements
- R1: With bypass low, each channel's output is built from s = current accepted sample + previous accepted sample of that channel, where samples are 4-bit two's complement.
- R2: The I and Q channels are computed independently: each channel uses only its own samples and its own tie direction.
- R3: Code k (0..7) represents k - 3.5. A sum s >= 4 gives code 7 and a sum s <= -4 gives code 0.
- R4: For -3 <= s <= 3 the code is s + 4 when the channel's tie direction is 0 and s + 3 when it is 1. The direction toggles after each such output and is unchanged by saturated outputs.
- R5: Per channel, the running sum of (level - clamp(s, -3.5, +3.5)) over all outputs since reset is always 0 or +0.5.
- R6: With bypass high at transfer, s is the current sample alone, mapped as in R3 and R4. The previous-sample register still loads that sample.
- R7: Reset clears the previous-sample registers and the tie directions to 0 and empties the output. The first output after reset therefore uses a previous sample of 0.
- R8: Every accepted sample yields exactly one output, in order. out_valid rises in the cycle after the transfer.
- R9: While out_valid is high and out_ready is low, out_valid stays high and both codes stay stable. in_ready equals (not out_valid) or out_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bypass | input | 1 | 1: quantise the current sample alone |
| in_valid | input | 1 | Input sample pair offered |
| in_ready | output | 1 | Stage can take the offered pair |
| i_sample | input | IN_W | I-channel sample, signed |
| q_sample | input | IN_W | Q-channel sample, signed |
| out_valid | output | 1 | Output codes present |
| out_ready | input | 1 | Downstream takes the codes |
| i_code | output | CODE_W | I-channel offset code |
| q_code | output | CODE_W | Q-channel offset code |

## Verification
Two things can happen in the same cycle: the output register hands its codes downstream, and a new sample transfers in and is quantised behind it. The bench sets up this case by keeping in_valid high while out_ready toggles at random. It checks that no code is lost, duplicated or reordered, and that in_ready follows the drain. The bypass pin also flips at random during these cycles, including cycles where a tie rounding toggles the direction. Every code is compared with a behavioural model, and the running bias stays within half a unit.

// File: rtl/cpa_pkg.sv
package cpa_pkg;
  localparam int unsigned LANES = 2;

  typedef enum logic {
    TIE_UP = 1'b0,
    TIE_DN = 1'b1
  } tie_dir_e;
endpackage

// File: rtl/cpa_quant.sv
module cpa_quant
  import cpa_pkg::*;
#(
  parameter int IN_W   = 4,
  parameter int CODE_W = 3
) (
  input  logic signed [IN_W:0]   sum_i,
  input  tie_dir_e               dir_i,
  output logic [CODE_W-1:0]      code_o,
  output logic                   tie_o
);
  localparam int HALF = 2 ** (CODE_W - 1);
  localparam int MAXK = 2 ** CODE_W - 1;

  int s;
  always_comb begin
    s = int'(sum_i);
    if (s >= HALF) begin
      code_o = CODE_W'(MAXK);
      tie_o  = 1'b0;
    end else if (s <= -HALF) begin
      code_o = '0;
      tie_o  = 1'b0;
    end else begin
      code_o = CODE_W'(s + HALF - ((dir_i == TIE_DN) ? 1 : 0));
      tie_o  = 1'b1;
    end
  end

  int lvl2, tgt2;
  always_comb begin
    lvl2 = 2 * int'(code_o) - MAXK;
    tgt2 = 2 * s;
    if (tgt2 > MAXK)  tgt2 = MAXK;
    if (tgt2 < -MAXK) tgt2 = -MAXK;
    // R3
    if (!$isunknown(sum_i))
      level_near_chk: assert ((lvl2 - tgt2 <= 1) && (tgt2 - lvl2 <= 1));
  end
endmodule

// File: rtl/cpa_lane.sv
module cpa_lane
  import cpa_pkg::*;
#(
  parameter int IN_W   = 4,
  parameter int CODE_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    accept_i,
  input  logic                    bypass_i,
  input  logic signed [IN_W-1:0]  sample_i,
  output logic [CODE_W-1:0]       code_o
);
  logic signed [IN_W-1:0] prev_q;
  tie_dir_e               dir_q;
  logic signed [IN_W:0]   sum;
  logic                   tie;

  always_comb begin
    if (bypass_i) sum = (IN_W+1)'(sample_i);
    else          sum = (IN_W+1)'(sample_i) + (IN_W+1)'(prev_q);
  end

  cpa_quant #(.IN_W(IN_W), .CODE_W(CODE_W)) u_quant (
    .sum_i (sum),
    .dir_i (dir_q),
    .code_o(code_o),
    .tie_o (tie)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      dir_q  <= TIE_UP;
    end else if (accept_i) begin
      prev_q <= sample_i;
      if (tie) dir_q <= (dir_q == TIE_UP) ? TIE_DN : TIE_UP;
    end
  end

  // R4
  sat_keeps_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i && !tie) |=> $stable(dir_q));

  // R4
  tie_flips_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i && tie) |=> (dir_q != $past(dir_q)));

  // R6
  prev_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_i |=> (prev_q == $past(sample_i)));
endmodule

// File: rtl/cpa_outreg.sv
module cpa_outreg #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] data_i,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] data_o
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      data_o    <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) data_o <= data_i;
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(data_o)));

  // R8
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R8
  idle_drains_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && out_ready) |=> !out_valid);
endmodule

// File: rtl/chip_pair_avg.sv
module chip_pair_avg
  import cpa_pkg::*;
#(
  parameter int IN_W   = 4,
  parameter int CODE_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bypass,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic signed [IN_W-1:0]  i_sample,
  input  logic signed [IN_W-1:0]  q_sample,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [CODE_W-1:0]       i_code,
  output logic [CODE_W-1:0]       q_code
);
  localparam int PW = LANES * CODE_W;

  logic signed [IN_W-1:0] samp [LANES];
  logic [PW-1:0]          codes_in;
  logic [PW-1:0]          codes_out;
  logic                   accept;

  assign samp[0] = i_sample;
  assign samp[1] = q_sample;
  assign accept  = in_valid && in_ready;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    cpa_lane #(.IN_W(IN_W), .CODE_W(CODE_W)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .accept_i(accept),
      .bypass_i(bypass),
      .sample_i(samp[g]),
      .code_o  (codes_in[g*CODE_W +: CODE_W])
    );
  end

  cpa_outreg #(.W(PW)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .data_i   (codes_in),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .data_o   (codes_out)
  );

  assign i_code = codes_out[0 +: CODE_W];
  assign q_code = codes_out[CODE_W +: CODE_W];

  // R9
  ready_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
endmodule

// File: tb/chip_pair_avg_tb.sv
module chip_pair_avg_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, bypass, in_valid, out_ready, in_ready, out_valid;
  logic signed [3:0] i_s, q_s;
  logic [2:0] i_c, q_c;

  chip_pair_avg u_dut (
    .clk(clk), .rst_n(rst_n), .bypass(bypass), .in_valid(in_valid),
    .in_ready(in_ready), .i_sample(i_s), .q_sample(q_s),
    .out_valid(out_valid), .out_ready(out_ready), .i_code(i_c), .q_code(q_c)
  );

  int errors = 0, checks = 0;
  bit done = 0;
  int prev_i = 0, prev_q = 0, dir_i = 0, dir_q = 0, cum_i = 0, cum_q = 0;
  int eq_i[$], eq_q[$], es_i[$], es_q[$];
  string tag_i[$], tag_q[$];
  bit first = 1;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clamp2(int s);
    int t = 2 * s;
    if (t > 7) t = 7;
    if (t < -7) t = -7;
    return t;
  endfunction

  task automatic model(int a, int p, bit byp, inout int dir, output int k,
                       output int s, output string tag);
    s = byp ? a : a + p;
    if (s >= 4) begin k = 7; tag = "R3 sat-high"; end
    else if (s <= -4) begin k = 0; tag = "R3 sat-low"; end
    else begin
      k = s + 4 - dir;
      dir = 1 - dir;
      tag = "R1/R4 tie";
    end
    if (byp) tag = {"R6 bypass ", tag};
    if (first) tag = {"R7 first ", tag};
  endtask

  task automatic step(bit v, bit r, int a, int b, bit byp);
    int k, s, ei, eqv, si, sq;
    string ti, tq;
    @(negedge clk);
    in_valid = v; out_ready = r; i_s = 4'(a); q_s = 4'(b); bypass = byp;
    #1;
    chk(in_ready == (!out_valid || out_ready), "R9 in_ready", int'(in_ready),
        int'(!out_valid || out_ready));
    chk(out_valid == (eq_i.size() > 0), "R8 out_valid", int'(out_valid),
        int'(eq_i.size() > 0));
    if (out_valid && out_ready && eq_i.size() > 0) begin
      ei = eq_i.pop_front(); eqv = eq_q.pop_front();
      si = es_i.pop_front(); sq = es_q.pop_front();
      ti = tag_i.pop_front(); tq = tag_q.pop_front();
      chk(int'(i_c) == ei, {ti, " I code"}, int'(i_c), ei);
      chk(int'(q_c) == eqv, {"R2 Q ", tq}, int'(q_c), eqv);
      cum_i += (2 * int'(i_c) - 7) - clamp2(si);
      cum_q += (2 * int'(q_c) - 7) - clamp2(sq);
      chk(cum_i == 0 || cum_i == 1, "R5 I bias (half units)", cum_i, 0);
      chk(cum_q == 0 || cum_q == 1, "R5 Q bias (half units)", cum_q, 0);
    end
    if (in_valid && in_ready) begin
      model(a, prev_i, byp, dir_i, k, s, ti);
      eq_i.push_back(k); es_i.push_back(s); tag_i.push_back(ti);
      model(b, prev_q, byp, dir_q, k, s, tq);
      eq_q.push_back(k); es_q.push_back(s); tag_q.push_back(tq);
      prev_i = a; prev_q = b; first = 0;
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bypass = 0; in_valid = 0; out_ready = 0; i_s = 0; q_s = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(out_valid == 0, "R7 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1, "R7 in_ready after reset", int'(in_ready), 1);
    // first sample sees a previous value of zero (R7)
    step(1, 1, 3, -2, 0);
    step(1, 1, 0, 0, 0);
    // every ordered pair of inputs, summing mode (R1, R3, R4)
    for (int a = -8; a < 8; a++)
      for (int b = -8; b < 8; b++) begin
        step(1, 1, a, ~b, 0);
        step(1, 1, b, ~a, 0);
      end
    // bypass sweep (R6)
    for (int a = -8; a < 8; a++) step(1, 1, a, ~a, 1);
    for (int a = -8; a < 8; a++) step(1, 1, a, a, 1);
    // stalls, concurrent drain and accept, bypass flips (R8, R9)
    for (int n = 0; n < 4000; n++)
      step($urandom_range(0, 3) != 0, $urandom_range(0, 2) != 0,
           $urandom_range(0, 15) - 8, $urandom_range(0, 15) - 8,
           $urandom_range(0, 7) == 0);
    // long stall then drain (R9)
    step(1, 0, 2, -3, 0);
    for (int n = 0; n < 5; n++) step(1, 0, 1, 1, 0);
    for (int n = 0; n < 4; n++) step(0, 1, 0, 0, 0);
    chk(eq_i.size() == 0, "R8 all outputs delivered", eq_i.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule